// File: doc/BRIEF.md
# Single-Wire Bus UART Transmitter with Collision Detection

This block serialises one frame at a time onto a shared single-wire line and watches the line it reads back. Each frame is a low start bit, nine data bits sent least significant bit first, and a high stop bit. Each bit lasts one period of an external bit-rate tick. While a frame is on the wire, the block compares the level it drives with the echoed receive level. A difference latches a collision flag. The comparison is made either at every bit tick or only when an external one-shot timer signals underflow. The timer mode lets the user place the sample point anywhere inside the bit.

A frame may start on the first bit tick once transmission is enabled and data is pending. It may instead wait for an active edge on the receive line, so that a node can synchronise to another node's start bit. A polarity input inverts both line pins. An option makes a collision clear the transmit-enable bit by itself, which abandons the frame at the next bit boundary. A one-cycle done pulse marks a frame that finished without a collision.

Top module: `swb_uart_tx`

## Requirements
- R1: A frame is the logical sequence 0 (start), data[0] through data[8], then 1 (stop). Each bit is held from one `baud_tick_i` pulse to the next.
- R2: The line idles at logical 1. With `pol_i`=1, `txd_o` is the complement of the logical level, and `rxd_i` is read as the complement of its pin level.
- R3: With `edge_start_i`=0, transmit enabled and data pending, the start bit appears on `txd_o` in the cycle after the next `baud_tick_i` pulse, and not before it.
- R4: With `edge_start_i`=1, bit ticks never start a frame. The start bit appears in the cycle after a logical 1-to-0 change of the receive line, which is a falling pin edge when `pol_i`=0 and a rising pin edge when `pol_i`=1.
- R5: In edge-start mode, an active edge that arrives before transmit is enabled does not start a frame, and a later steady level does not start one either.
- R6: With `samp_sel_i`=0, a mismatch between the driven logical bit and the logical receive level during a frame, present at a `baud_tick_i` pulse, sets `coll_o` in the next cycle.
- R7: With `samp_sel_i`=1, the mismatch is judged only at a `timer_uf_i` pulse. A mismatch present at a bit tick alone leaves `coll_o` at 0.
- R8: `coll_o` stays at 1 until a `coll_clr_i` pulse. A detection in the same cycle as the clear keeps the flag at 1.
- R9: With `auto_off_i`=1, a detection clears `te_o` in the same cycle in which `coll_o` rises, and this takes priority over a write to the enable bit.
- R10: When `te_o` is 0 at a bit tick during a frame, the line returns to idle at that tick, the frame and its data are dropped, and no done pulse follows. Bits that remain before that tick are still sent.
- R11: `done_o` is 1 for exactly one cycle, in the cycle after the tick that ends the stop bit, and only if no collision was detected during that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | One-cycle pulse at each bit boundary |
| timer_uf_i | input | 1 | One-cycle pulse from the one-shot timer underflow |
| samp_sel_i | input | 1 | Collision sample source: 0 bit tick, 1 timer pulse |
| auto_off_i | input | 1 | 1: a collision clears the transmit-enable bit |
| edge_start_i | input | 1 | 1: a frame starts on an active receive edge |
| pol_i | input | 1 | 1: both line pins are inverted |
| data_wr_i | input | 1 | Loads `data_i` as pending frame data while the block is idle |
| data_i | input | DATA_W | Frame data, sent bit 0 first |
| te_wr_i | input | 1 | Write strobe for the transmit-enable bit |
| te_wdata_i | input | 1 | Value written to the transmit-enable bit |
| coll_clr_i | input | 1 | Write-one-to-clear strobe for the collision flag |
| rxd_i | input | 1 | Echoed line level, synchronous to `clk_i` |
| txd_o | output | 1 | Driven line level |
| te_o | output | 1 | Transmit-enable bit |
| coll_o | output | 1 | Latched collision flag |
| done_o | output | 1 | One-cycle pulse when a clean frame completes |

## Verification
Three pairs of events can land in the same clock cycle. A collision detection can meet a software clear of the flag. A detection can meet a write to the enable bit. A bit tick can meet the timer pulse while timer sampling is selected. The bench forces the echoed line to the wrong level and raises the clear strobe together with the tick that judges the mismatch. It then checks that the flag still reads 1 in the next cycle. In timer mode it forces a mismatch across a tick and checks that the flag stays 0, then checks that a later timer pulse sets it.

// File: rtl/swb_pkg.sv
package swb_pkg;
  localparam int unsigned SWB_DATA_W = 9;

  typedef struct packed {
    logic samp_tmr;    // judge collisions on timer pulse
    logic auto_off;    // collision drops enable
    logic edge_start;  // start waits for rxd edge
    logic inv;         // line polarity inverted
  } swb_mode_t;
endpackage

// File: rtl/swb_start_ctl.sv
module swb_start_ctl (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  swb_pkg::swb_mode_t mode_i,
  input  logic               baud_tick_i,
  input  logic               rxd_log_i,
  input  logic               cond_i,
  input  logic               busy_i,
  output logic               start_o
);
  logic rxd_prev_q;
  logic act_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rxd_prev_q <= 1'b1;
    else         rxd_prev_q <= rxd_log_i;
  end

  // logical 1->0 is the active edge for either polarity
  assign act_edge = rxd_prev_q & ~rxd_log_i;

  always_comb begin
    if (mode_i.edge_start) start_o = ~busy_i & cond_i & act_edge;
    else                   start_o = ~busy_i & cond_i & baud_tick_i;
  end
endmodule

// File: rtl/swb_serializer.sv
module swb_serializer #(
  parameter int unsigned DATA_W = swb_pkg::SWB_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              baud_tick_i,
  input  logic              te_i,
  input  logic              det_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              tx_bit_o,
  output logic              fin_o,
  output logic              done_o
);
  localparam int unsigned FRAME_LEN = DATA_W + 2;
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic                 busy_q, fcoll_q, done_q;
  logic [FRAME_LEN-1:0] sh_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 adv, at_last;

  assign adv     = busy_q & baud_tick_i;
  assign at_last = (cnt_q == LAST);
  assign fin_o   = adv & (~te_i | at_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      sh_q    <= '1;
      cnt_q   <= '0;
      fcoll_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q  <= 1'b1;
        sh_q    <= {1'b1, data_i, 1'b0};
        cnt_q   <= '0;
        fcoll_q <= 1'b0;
      end else begin
        if (busy_q && det_i) fcoll_q <= 1'b1;
        if (adv) begin
          if (!te_i) begin
            busy_q <= 1'b0;  // abandon frame
          end else if (at_last) begin
            busy_q <= 1'b0;
            done_q <= ~(fcoll_q | det_i);
          end else begin
            sh_q  <= {1'b1, sh_q[FRAME_LEN-1:1]};
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign busy_o   = busy_q;
  assign tx_bit_o = busy_q ? sh_q[0] : 1'b1;
  assign done_o   = done_q;
endmodule

// File: rtl/swb_coll_det.sv
module swb_coll_det (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  swb_pkg::swb_mode_t mode_i,
  input  logic               busy_i,
  input  logic               baud_tick_i,
  input  logic               timer_uf_i,
  input  logic               tx_bit_i,
  input  logic               rxd_log_i,
  input  logic               clr_i,
  input  logic               te_wr_i,
  input  logic               te_wdata_i,
  output logic               det_o,
  output logic               coll_o,
  output logic               te_o
);
  logic coll_q, te_q, samp_ev;

  assign samp_ev = mode_i.samp_tmr ? timer_uf_i : baud_tick_i;
  assign det_o   = busy_i & samp_ev & (tx_bit_i ^ rxd_log_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coll_q <= 1'b0;
      te_q   <= 1'b0;
    end else begin
      if (det_o)      coll_q <= 1'b1;  // detection beats clear
      else if (clr_i) coll_q <= 1'b0;

      if (det_o && mode_i.auto_off) te_q <= 1'b0;
      else if (te_wr_i)             te_q <= te_wdata_i;
    end
  end

  assign coll_o = coll_q;
  assign te_o   = te_q;
endmodule

// File: rtl/swb_uart_tx.sv
module swb_uart_tx #(
  parameter int unsigned DATA_W = swb_pkg::SWB_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic              timer_uf_i,
  input  logic              samp_sel_i,
  input  logic              auto_off_i,
  input  logic              edge_start_i,
  input  logic              pol_i,
  input  logic              data_wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              te_wr_i,
  input  logic              te_wdata_i,
  input  logic              coll_clr_i,
  input  logic              rxd_i,
  output logic              txd_o,
  output logic              te_o,
  output logic              coll_o,
  output logic              done_o
);
  swb_pkg::swb_mode_t mode;
  logic [DATA_W-1:0]  data_q;
  logic               valid_q;
  logic               rxd_log, tx_bit, busy, start, fin, det, te, cond;

  assign mode    = '{samp_tmr: samp_sel_i, auto_off: auto_off_i,
                     edge_start: edge_start_i, inv: pol_i};
  assign rxd_log = rxd_i ^ pol_i;
  assign txd_o   = tx_bit ^ pol_i;
  assign cond    = te & valid_q;
  assign te_o    = te;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else if (fin) begin
      valid_q <= 1'b0;
    end else if (data_wr_i && !busy && !start) begin
      data_q  <= data_i;
      valid_q <= 1'b1;
    end
  end

  swb_start_ctl u_start (
    .clk_i, .rst_ni, .mode_i(mode), .baud_tick_i, .rxd_log_i(rxd_log),
    .cond_i(cond), .busy_i(busy), .start_o(start)
  );

  swb_serializer #(.DATA_W(DATA_W)) u_ser (
    .clk_i, .rst_ni, .start_i(start), .baud_tick_i, .te_i(te), .det_i(det),
    .data_i(data_q), .busy_o(busy), .tx_bit_o(tx_bit), .fin_o(fin),
    .done_o
  );

  swb_coll_det u_det (
    .clk_i, .rst_ni, .mode_i(mode), .busy_i(busy), .baud_tick_i,
    .timer_uf_i, .tx_bit_i(tx_bit), .rxd_log_i(rxd_log),
    .clr_i(coll_clr_i), .te_wr_i, .te_wdata_i, .det_o(det),
    .coll_o, .te_o(te)
  );
endmodule

// File: rtl/swb_uart_tx_chk.sv
module swb_uart_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic baud_tick_i,
  input logic timer_uf_i,
  input logic samp_sel_i,
  input logic auto_off_i,
  input logic pol_i,
  input logic coll_clr_i,
  input logic busy,
  input logic txd_o,
  input logic te_o,
  input logic coll_o,
  input logic done_o
);
  a_r11_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_coll_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coll_o && !coll_clr_i |=> coll_o);

  a_r9_auto_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(coll_o) && $past(auto_off_i) |-> !te_o);

  a_r2_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> txd_o == !pol_i);

  a_r7_tmr_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(coll_o) && $past(samp_sel_i) |-> $past(timer_uf_i));

  a_r6_tick_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(coll_o) && !$past(samp_sel_i) |-> $past(baud_tick_i));

  a_r11_done_after_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy && $past(busy));
endmodule

bind swb_uart_tx swb_uart_tx_chk u_chk (
  .clk_i, .rst_ni, .baud_tick_i, .timer_uf_i, .samp_sel_i, .auto_off_i,
  .pol_i, .coll_clr_i, .busy(busy), .txd_o, .te_o, .coll_o, .done_o
);

// File: tb/tb_swb_uart_tx.sv
`timescale 1ns/1ps
module tb_swb_uart_tx;
  localparam int unsigned DW = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic baud_tick = 0, timer_uf = 0, samp_sel = 0, auto_off = 0;
  logic edge_start = 0, pol = 0, data_wr = 0, te_wr = 0, te_wdata = 0;
  logic coll_clr = 0, frc_en = 0, frc_val = 0;
  logic [DW-1:0] data = '0;
  logic rxd, txd, te, coll, done;
  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  assign rxd = frc_en ? frc_val : txd;

  swb_uart_tx dut (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(baud_tick), .timer_uf_i(timer_uf),
    .samp_sel_i(samp_sel), .auto_off_i(auto_off), .edge_start_i(edge_start),
    .pol_i(pol), .data_wr_i(data_wr), .data_i(data), .te_wr_i(te_wr),
    .te_wdata_i(te_wdata), .coll_clr_i(coll_clr), .rxd_i(rxd), .txd_o(txd),
    .te_o(te), .coll_o(coll), .done_o(done)
  );

  // {pol, data}
  localparam logic [DW:0] VEC [0:5] = '{10'h155, 10'h2aa, 10'h3ff,
                                        10'h201, 10'h100, 10'h0c3};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic tick();
    baud_tick = 1; step(); baud_tick = 0;
  endtask

  task automatic load(input logic [DW-1:0] d);
    data = d; data_wr = 1; step(); data_wr = 0;
  endtask

  task automatic set_te(input logic v);
    te_wdata = v; te_wr = 1; step(); te_wr = 0;
  endtask

  task automatic clr_coll();
    coll_clr = 1; step(); coll_clr = 0;
  endtask

  // after start bit is on the line: walk data, stop, end
  task automatic walk_rest(input logic [DW-1:0] d, input logic expect_done, input string req);
    for (int i = 0; i < DW; i++) begin
      tick();
      chk({req, " R1 data bit"}, txd, d[i] ^ pol);
    end
    tick();
    chk({req, " R1 stop bit"}, txd, 1'b1 ^ pol);
    tick();
    chk({req, " R11 done"}, done, expect_done);
    step();
    chk({req, " R11 done pulse width"}, done, 1'b0);
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    step(); step();
    chk("R2 reset txd idle", txd, 1'b1);
    chk("R8 reset coll", coll, 1'b0);
    chk("R11 reset done", done, 1'b0);
    chk("R9 reset te", te, 1'b0);
    rst_n = 1;
    step();

    // table: level-start frames, echoed line
    set_te(1);
    for (int v = 0; v < 6; v++) begin
      pol = VEC[v][DW];
      step(); step();
      chk("R2 idle level", txd, !pol);
      load(VEC[v][DW-1:0]);
      step(); step();
      chk("R3 no start before tick", txd, !pol);
      tick();
      chk("R3 start bit after tick", txd, pol);
      walk_rest(VEC[v][DW-1:0], 1'b1, "table");
      chk("R6 no collision on echo", coll, 1'b0);
    end
    pol = 0;
    step(); step();

    // tick sampling collision, no auto-off
    load(9'h0F0);
    tick();
    tick();                       // D0 = 0 on line
    frc_en = 1; frc_val = 1;
    step();
    chk("R6 no detect without tick", coll, 1'b0);
    tick();
    chk("R6 collision at tick", coll, 1'b1);
    chk("R9 te kept when auto-off 0", te, 1'b1);
    frc_en = 0;
    repeat (8) tick();
    tick();
    chk("R11 no done after collision", done, 1'b0);
    chk("R8 flag latched", coll, 1'b1);
    clr_coll();
    chk("R8 cleared by strobe", coll, 1'b0);

    // timer sampling
    samp_sel = 1;
    load(9'h00F);
    tick();
    tick();                       // D0 = 1
    frc_en = 1; frc_val = 0;
    tick();                       // mismatch at tick only, D1 now shown
    chk("R7 tick ignored in timer mode", coll, 1'b0);
    timer_uf = 1; step(); timer_uf = 0;
    chk("R7 collision at timer pulse", coll, 1'b1);
    frc_en = 0;
    repeat (9) tick();
    chk("R11 no done after timer collision", done, 1'b0);
    clr_coll();
    samp_sel = 0;

    // detection and clear in same cycle
    load(9'h000);
    tick();                       // start (0)
    frc_en = 1; frc_val = 1;
    coll_clr = 1; baud_tick = 1; step(); coll_clr = 0; baud_tick = 0;
    chk("R8 detect beats clear", coll, 1'b1);
    frc_en = 0;
    repeat (10) tick();
    clr_coll();
    chk("R8 clear after frame", coll, 1'b0);

    // auto-off and abort
    auto_off = 1;
    load(9'h000);
    tick();
    tick();                       // D0 = 0
    frc_en = 1; frc_val = 1;
    te_wdata = 1; te_wr = 1; baud_tick = 1; step(); te_wr = 0; baud_tick = 0;
    frc_en = 0;
    chk("R9 te cleared on collision", te, 1'b0);
    chk("R9 flag set", coll, 1'b1);
    chk("R10 bit still sent before boundary", txd, 1'b0);
    tick();
    chk("R10 idle at next boundary", txd, 1'b1);
    repeat (10) begin
      tick();
      chk("R11 no done after abort", done, 1'b0);
    end
    set_te(1);
    auto_off = 0;
    clr_coll();
    tick(); step();
    chk("R10 dropped data not resent", txd, 1'b1);

    // edge start, pol 0
    edge_start = 1;
    load(9'h155);
    tick(); tick();
    chk("R4 ticks do not start", txd, 1'b1);
    frc_en = 1; frc_val = 0;
    step();
    chk("R4 start on falling edge", txd, 1'b0);
    frc_en = 0;
    walk_rest(9'h155, 1'b1, "edge pol0");

    // edge start, pol 1
    pol = 1;
    step(); step();
    load(9'h0A3);
    tick();
    chk("R4 pol1 ticks do not start", txd, 1'b0);
    frc_en = 1; frc_val = 1;
    step();
    chk("R4 start on rising pin edge", txd, 1'b1);
    frc_en = 0;
    walk_rest(9'h0A3, 1'b1, "edge pol1");
    pol = 0;
    step(); step();

    // edge before enable
    set_te(0);
    load(9'h011);
    frc_en = 1; frc_val = 0;
    step();
    set_te(1);
    step(); tick(); tick();
    chk("R5 early edge ignored", txd, 1'b0 ^ frc_val ^ frc_val ^ 1'b1);
    frc_en = 0;
    step(); tick();
    chk("R5 steady level no start", txd, 1'b1);
    frc_en = 1; frc_val = 0;
    step();
    chk("R5 later edge starts", txd, 1'b0);
    frc_en = 0;
    walk_rest(9'h011, 1'b1, "edge late");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule